// File: doc/BRIEF.md
# Lane-Split Pixel and Bit-Field Data Unit

This block is a 32-bit data-path stage for pixel and bit-field code. One opcode per clock picks the operation. Arithmetic runs across the whole word or in independent narrower lanes, with no carry crossing a lane edge. The other operations are: fill a word with copies of one, two or four low source bits; find the highest or lowest set bit, or the highest or lowest place where two neighbouring bits differ; and build a mask of low-order ones from a 5-bit count.

Operands and opcode are sampled on a rising clock edge. The result, a carry vector with one bit per lane, and a found flag from the detection operations all come from registers. Each one appears one clock after the operands.

Top module: `pixel_field_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o`, `carry_o` and `found_o` are all zero after that edge.
- R2: Opcode 0 adds `a_i` and `b_i` per lane. `lane_i` 0 or 3 gives one 32-bit lane, 1 gives two 16-bit lanes, and 2 gives four 8-bit lanes. No carry crosses a lane edge. `carry_o[k]` is the carry out of lane k, counted from the least significant lane. Unused carry bits are zero.
- R3: Opcode 1 subtracts `b_i` from `a_i` per lane, with the same lane layout as R2. `carry_o[k]` is 1 when lane k did not borrow.
- R4: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of `a_i` and `b_i`. For these, `carry_o` and `found_o` are zero.
- R5: Opcode 5 copies `a_i[0]` into all 32 result bits.
- R6: Opcode 6 puts 16 copies of `a_i[0]` in result bits 15:0 and 16 copies of `a_i[1]` in bits 31:16.
- R7: Opcode 7 fills result byte k (bits 8k+7:8k) with copies of `a_i[k]`, for k = 0 to 3.
- R8: Opcode 8 reports the index of the highest set bit of `a_i` in `res_o[4:0]`. Opcode 9 reports the lowest. In both cases `found_o` is 1 and `res_o[31:5]` is zero.
- R9: Opcodes 10 and 11 report the highest and the lowest index i, from 1 to 31, with `a_i[i]` different from `a_i[i-1]`. The index goes in `res_o[4:0]` and `found_o` is 1.
- R10: When a detection opcode (8 to 11) finds no set bit or no transition, `found_o` is 0 and `res_o` is zero. This covers an all-zero input, or an input with all bits equal.
- R11: Opcode 12 gives a result whose low `a_i[4:0]` bits are ones and whose other bits are zero. A count of 0 gives zero.
- R12: Opcodes 13, 14 and 15 give zero on `res_o`, `carry_o` and `found_o`. `carry_o` is zero for every opcode other than 0 and 1, and `found_o` is zero for every opcode other than 8 to 11.
- R13: Every result appears on the outputs one clock after its operands are sampled, and stays there for exactly that one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation select, coded as in the requirements |
| lane_i | input | 2 | Lane split for opcodes 0 and 1 |
| a_i | input | 32 | First operand and source for expand, detect and mask |
| b_i | input | 32 | Second operand |
| res_o | output | 32 | Registered result |
| carry_o | output | 4 | Registered per-lane carry-out |
| found_o | output | 1 | Registered detection-success flag |

## Verification
Every operation passes through a single result register, so all three outputs for the operands driven before edge N are due just after edge N. Nothing is due earlier or later. The bench drives one new vector on each falling edge and computes its expected value from a behavioural model. It compares at the next falling edge, half a period after the capturing edge, so each comparison covers the vector of the previous clock. Because a new vector is compared on every clock, a result that came one cycle late or stayed one cycle too long would show up as a mismatch.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_REP1 = 4'd5,
        OP_REP2 = 4'd6,
        OP_REP4 = 4'd7,
        OP_LONE = 4'd8,
        OP_RONE = 4'd9,
        OP_LCHG = 4'd10,
        OP_RCHG = 4'd11,
        OP_MASK = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        LANE_FULL = 2'd0,
        LANE_HALF = 2'd1,
        LANE_BYTE = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        REP_ONE  = 2'd0,
        REP_TWO  = 2'd1,
        REP_FOUR = 2'd2
    } rep_e;

    // A chunk k opens a new lane when carry must be cut below it.
    function automatic logic chunk_opens_lane(input logic [1:0] mode, input int k, input int nchunk);
        return (k == 0) || (mode == LANE_BYTE) || ((mode == LANE_HALF) && (k == nchunk / 2));
    endfunction

    // A chunk k closes a lane when its carry-out is reported.
    function automatic logic chunk_closes_lane(input logic [1:0] mode, input int k, input int nchunk);
        return (k == nchunk - 1) || (mode == LANE_BYTE) || ((mode == LANE_HALF) && (k == nchunk / 2 - 1));
    endfunction

    // Index of the carry bit that the lane ending at chunk k drives.
    function automatic int carry_slot(input logic [1:0] mode, input int k, input int nchunk);
        if (mode == LANE_BYTE) return k;
        if (mode == LANE_HALF) return k / (nchunk / 2);
        return 0;
    endfunction

endpackage

// File: rtl/pfu_seg_adder.sv
module pfu_seg_adder
    import pfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8,
    localparam int NCHUNK = DATA_W / CHUNK_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] sum,
    output logic [NCHUNK-1:0] carry
);
    logic [NCHUNK-1:0] chunk_cin;
    logic [NCHUNK-1:0] chunk_cout;

    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
        logic [CHUNK_W:0]   part;
        logic [CHUNK_W-1:0] b_eff;

        if (k == 0) begin : g_first
            assign chunk_cin[k] = sub;
        end else begin : g_rest
            assign chunk_cin[k] = chunk_opens_lane(mode, k, NCHUNK) ? sub : chunk_cout[k-1];
        end

        assign b_eff = b[k*CHUNK_W +: CHUNK_W] ^ {CHUNK_W{sub}};
        assign part  = {1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, b_eff}
                     + {{CHUNK_W{1'b0}}, chunk_cin[k]};
        assign sum[k*CHUNK_W +: CHUNK_W] = part[CHUNK_W-1:0];
        assign chunk_cout[k] = part[CHUNK_W];
    end

    always_comb begin
        carry = '0;
        for (int k = 0; k < NCHUNK; k++) begin
            if (chunk_closes_lane(mode, k, NCHUNK)) begin
                carry[carry_slot(mode, k, NCHUNK)] = chunk_cout[k];
            end
        end
    end
endmodule

// File: rtl/pfu_expander.sv
module pfu_expander
    import pfu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        src,
    input  rep_e              kind,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] rep_one, rep_two, rep_four;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign rep_one[i]  = src[0];
        assign rep_two[i]  = src[i / (DATA_W / 2)];
        assign rep_four[i] = src[i / (DATA_W / 4)];
    end

    always_comb begin
        unique case (kind)
            REP_TWO:  word = rep_two;
            REP_FOUR: word = rep_four;
            default:  word = rep_one;
        endcase
    end
endmodule

// File: rtl/pfu_bit_detect.sv
module pfu_bit_detect #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] vec,
    input  logic              from_left,
    input  logic              on_change,
    output logic [POS_W-1:0]  pos,
    output logic              found
);
    logic [DATA_W-1:0] edges;
    logic [DATA_W-1:0] target;

    // Bit i of edges marks vec[i] != vec[i-1]; bit 0 has no lower neighbour.
    assign edges  = (vec ^ {vec[DATA_W-2:0], 1'b0}) & ~{{(DATA_W-1){1'b0}}, 1'b1};
    assign target = on_change ? edges : vec;
    assign found  = |target;

    always_comb begin
        pos = '0;
        if (from_left) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (target[i]) pos = POS_W'(i);
            end
        end else begin
            for (int i = DATA_W - 1; i >= 0; i--) begin
                if (target[i]) pos = POS_W'(i);
            end
        end
    end
endmodule

// File: rtl/pfu_mask_gen.sv
module pfu_mask_gen #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [POS_W-1:0]  count,
    output logic [DATA_W-1:0] mask
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask[i] = (POS_W'(i) < count);
    end
endmodule

// File: rtl/pixel_field_unit.sv
module pixel_field_unit
    import pfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8,
    localparam int NCHUNK = DATA_W / CHUNK_W,
    localparam int POS_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [1:0]        lane_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic [NCHUNK-1:0] carry_o,
    output logic              found_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NCHUNK-1:0] carry;
        logic              found;
    } result_t;

    op_e               op;
    rep_e              rep_kind;
    logic [DATA_W-1:0] sum, rep_word, mask_word;
    logic [NCHUNK-1:0] sum_carry;
    logic [POS_W-1:0]  det_pos;
    logic              det_found;
    result_t           nxt, cur;

    assign op = op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_REP2: rep_kind = REP_TWO;
            OP_REP4: rep_kind = REP_FOUR;
            default: rep_kind = REP_ONE;
        endcase
    end

    pfu_seg_adder #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) i_adder (
        .a    (a_i),
        .b    (b_i),
        .sub  (op == OP_SUB),
        .mode (lane_i),
        .sum  (sum),
        .carry(sum_carry)
    );

    pfu_expander #(.DATA_W(DATA_W)) i_expander (
        .src (a_i[3:0]),
        .kind(rep_kind),
        .word(rep_word)
    );

    pfu_bit_detect #(.DATA_W(DATA_W)) i_detect (
        .vec      (a_i),
        .from_left((op == OP_LONE) || (op == OP_LCHG)),
        .on_change((op == OP_LCHG) || (op == OP_RCHG)),
        .pos      (det_pos),
        .found    (det_found)
    );

    pfu_mask_gen #(.DATA_W(DATA_W)) i_mask (
        .count(a_i[POS_W-1:0]),
        .mask (mask_word)
    );

    always_comb begin
        nxt = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                nxt.data  = sum;
                nxt.carry = sum_carry;
            end
            OP_AND: nxt.data = a_i & b_i;
            OP_OR:  nxt.data = a_i | b_i;
            OP_XOR: nxt.data = a_i ^ b_i;
            OP_REP1, OP_REP2, OP_REP4: nxt.data = rep_word;
            OP_LONE, OP_RONE, OP_LCHG, OP_RCHG: begin
                nxt.found = det_found;
                nxt.data  = det_found ? {{(DATA_W-POS_W){1'b0}}, det_pos} : '0;
            end
            OP_MASK: nxt.data = mask_word;
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign res_o   = cur.data;
    assign carry_o = cur.carry;
    assign found_o = cur.found;
endmodule

// File: rtl/pfu_checker.sv
module pfu_checker
    import pfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CHUNK_W = 8,
    localparam int NCHUNK = DATA_W / CHUNK_W,
    localparam int POS_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic [1:0]        lane_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] res_o,
    input logic [NCHUNK-1:0] carry_o,
    input logic              found_o
);
    logic unused_b;
    assign unused_b = ^b_i;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res_o == '0 && carry_o == '0 && !found_o));

    assert_full_lane_one_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD && (lane_i == LANE_FULL || lane_i == 2'd3)) |=> (carry_o[NCHUNK-1:1] == '0));

    assert_logic_no_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> (carry_o == '0 && !found_o));

    assert_rep_uniform_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_REP1) |=> (res_o == '0 || res_o == '1));

    assert_found_position_range_R8: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (res_o[DATA_W-1:POS_W] == '0));

    assert_not_found_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i >= OP_LONE && op_i <= OP_RCHG) |=> (found_o || res_o == '0));

    assert_mask_shape_R11: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MASK) |=> ((res_o & (res_o + {{(DATA_W-1){1'b0}}, 1'b1})) == '0
                               && $countones(res_o) == int'($past(a_i[POS_W-1:0]))));

    assert_unused_op_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_MASK) |=> (res_o == '0 && carry_o == '0 && !found_o));

    assert_found_only_detect_R12: assert property (@(posedge clk) disable iff (rst)
        (op_i < OP_LONE || op_i > OP_RCHG) |=> !found_o);
endmodule

bind pixel_field_unit pfu_checker #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) i_pfu_checker (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op_i),
    .lane_i (lane_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (res_o),
    .carry_o(carry_o),
    .found_o(found_o)
);

// File: tb/test_pixel_field_unit.sv
`timescale 1ns/1ps
module test_pixel_field_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [1:0]  lane_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;
    logic [3:0]  carry_o;
    logic        found_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pixel_field_unit i_pixel_field_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .lane_i(lane_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .carry_o(carry_o), .found_o(found_o)
    );

    function automatic string req_tag(input int op, input logic f);
        if (op >= 8 && op <= 11 && !f) return "R10";
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8, 9: return "R8";
            10, 11: return "R9";
            12: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Behavioural reference, written from the requirements.
    task automatic model(input int op, input int lane, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic [3:0] c, output logic f);
        int w;
        r = '0; c = '0; f = 1'b0;
        w = (lane == 1) ? 16 : (lane == 2) ? 8 : 32;
        case (op)
            0, 1: begin
                for (int l = 0; l < 32 / w; l++) begin
                    longint unsigned m, x, y, s;
                    m = (64'd1 << w) - 1;
                    x = (64'(a) >> (l * w)) & m;
                    y = (64'(b) >> (l * w)) & m;
                    if (op == 1) y = (~y) & m;
                    s = x + y + ((op == 1) ? 64'd1 : 64'd0);
                    r = r | (32'(s & m) << (l * w));
                    c[l] = s[w];
                end
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: for (int i = 0; i < 32; i++) r[i] = a[0];
            6: for (int i = 0; i < 32; i++) r[i] = (i < 16) ? a[0] : a[1];
            7: for (int i = 0; i < 32; i++) r[i] = a[i / 8];
            8: for (int i = 0; i < 32; i++) if (a[i]) begin r = i; f = 1'b1; end
            9: for (int i = 31; i >= 0; i--) if (a[i]) begin r = i; f = 1'b1; end
            10: for (int i = 1; i < 32; i++) if (a[i] != a[i-1]) begin r = i; f = 1'b1; end
            11: for (int i = 31; i >= 1; i--) if (a[i] != a[i-1]) begin r = i; f = 1'b1; end
            12: for (int i = 0; i < 32; i++) r[i] = (i < int'(a[4:0]));
            default: ;
        endcase
    endtask

    // Called at a falling edge: drive, then compare one clock later (R13).
    task automatic apply(input int op, input int lane, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er; logic [3:0] ec; logic ef;
        op_i = 4'(op); lane_i = 2'(lane); a_i = a; b_i = b;
        model(op, lane, a, b, er, ec, ef);
        @(negedge clk);
        checks++;
        if (res_o !== er || carry_o !== ec || found_o !== ef) begin
            fails++;
            $display("FAIL %s/R13 op=%0d lane=%0d a=%h b=%h: res=%h carry=%b found=%b expected res=%h carry=%b found=%b",
                     req_tag(op, ef), op, lane, a, b, res_o, carry_o, found_o, er, ec, ef);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs clear while reset is held, despite live operands.
        op_i = 4'd3; a_i = 32'hFFFF_FFFF; b_i = 32'h1234_5678;
        repeat (3) @(negedge clk);
        checks++;
        if (res_o !== '0 || carry_o !== '0 || found_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: res=%h carry=%b found=%b expected res=0 carry=0 found=0",
                     res_o, carry_o, found_o);
        end
        rst = 1'b0;

        // R2: carries cut at lane edges.
        apply(0, 0, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(0, 3, 32'h8000_0000, 32'h8000_0001);
        apply(0, 1, 32'hFFFF_0001, 32'h0001_FFFF);
        apply(0, 2, 32'h80FF_7F01, 32'h8001_7F01);
        // R3: per-lane borrow.
        apply(1, 0, 32'h0000_0000, 32'h0000_0001);
        apply(1, 1, 32'h0005_0003, 32'h0003_0005);
        apply(1, 2, 32'h0010_FF01, 32'h0110_FF02);
        // R4
        apply(2, 0, 32'hF0F0_AAAA, 32'hFF00_5555);
        apply(3, 1, 32'hF0F0_AAAA, 32'hFF00_5555);
        apply(4, 2, 32'hF0F0_AAAA, 32'hFF00_5555);
        // R5, R6, R7
        apply(5, 0, 32'h0000_0001, 32'h0);
        apply(5, 0, 32'hFFFF_FFFE, 32'h0);
        apply(6, 0, 32'h0000_0002, 32'h0);
        apply(6, 0, 32'h0000_0001, 32'h0);
        apply(7, 0, 32'h0000_000A, 32'h0);
        apply(7, 0, 32'hFFFF_FFF5, 32'h0);
        // R8, R9, R10
        apply(8, 0, 32'h0001_0080, 32'h0);
        apply(9, 0, 32'h0001_0080, 32'h0);
        apply(8, 0, 32'h8000_0000, 32'h0);
        apply(9, 0, 32'h0000_0001, 32'h0);
        apply(10, 0, 32'hFFFF_0000, 32'h0);
        apply(11, 0, 32'h0000_0001, 32'h0);
        apply(10, 0, 32'h0F00_0F00, 32'h0);
        apply(11, 0, 32'h0F00_0F00, 32'h0);
        apply(8, 0, 32'h0, 32'h0);
        apply(9, 0, 32'h0, 32'h0);
        apply(10, 0, 32'hFFFF_FFFF, 32'h0);
        apply(11, 0, 32'h0, 32'h0);
        // R11 boundaries
        apply(12, 0, 32'h0, 32'h0);
        apply(12, 0, 32'h1, 32'h0);
        apply(12, 0, 32'hFFFF_FFFF, 32'h0);
        // R12
        apply(13, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(15, 2, 32'h1234_5678, 32'h9ABC_DEF0);
        // Mixed random stream, one vector per clock.
        for (int n = 0; n < 2000; n++) begin
            apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 3)), $urandom, $urandom);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule